// File: doc/BRIEF.md
# Self-Adaptive Mode-Controlled Address Decoder

The block turns a 10-bit address into 1024 active-high word lines. Exactly one line is high. The decode is not built from wide AND gates. It is a chain of nine two-input gate stages, and NOR and NAND stages alternate along the chain. The first stage is a NOR stage. It uses the two lowest address bits, two inverters and four NOR gates, and produces four lines. Each later stage s brings in address bit s through one inverter shared by the stage. That stage has two equal blocks of gates: one block is fed the true bit and the other the inverted bit. The number of outputs doubles at every stage. The outputs of the NAND stages are active-low. The next NOR stage returns them to active-high, and the chain ends on a NOR stage.

Each stage also carries a small controller for each of its two halves. The controller decides whether that half is clocked (dynamic) or held at a fixed level (static). A global mode selects one of three behaviours. In fully static mode every half is held. In fully dynamic mode every half is clocked. In mixed mode only the half that contains the selected path is clocked, and the stage's own address bit decides which half that is. The control vector goes out next to the word lines, so that downstream gate-level logic can use it.

Top module: `adaptive_decoder`

## Requirements
- R1: While reset is held, and on the first output cycle after reset, all word lines are 0 and every control bit is at its static level.
- R2: The address and mode are captured on a rising clock edge. The word lines and the control enables that come from them change on the following rising edge, so the latency is two edges from input to output.
- R3: Exactly one word line is high: line index equals the binary address value, for every address from 0 to 1023.
- R4: Mode code 2'b00 (static), and also the unused code 2'b11, hold every control bit at its static level whatever the address. The static level is 1 for NAND stages (stages 2, 4, 6 and 8) and 0 for NOR stages (stages 1, 3, 5, 7 and 9).
- R5: In mixed mode (code 2'b01), a NAND stage clocks its true-bit half when its stage bit is 1 and its inverted-bit half when the bit is 0. The other half is static.
- R6: In mixed mode, a NOR stage clocks its true-bit half when its stage bit is 0 and its inverted-bit half when the bit is 1. The other half is static.
- R7: A clocked half on a NAND stage outputs the clock itself. A clocked half on a NOR stage outputs the inverted clock.
- R8: In dynamic mode (code 2'b10), every half of every stage is clocked. The two bits of each stage are therefore always equal.
- R9: The control vector has two bits per stage, starting with stage 1 at bit 0. Bit 2(s-1) is the true-bit half of stage s and bit 2(s-1)+1 is its inverted-bit half. Stage s is steered by address bit s, so stage 1 is steered by bit 1.
- R10: The mode has no effect on which word line is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active; also the source of the clocked control levels |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | 10 | Address to decode |
| mode_i | input | 2 | 00 static, 01 mixed, 10 dynamic, 11 treated as static |
| word_o | output | 1024 | One-hot word lines, registered |
| ctrl_o | output | 18 | Per-half control: a held level, or the clock / inverted clock |

## Verification
The assertions assume that address and mode are settled at every rising edge, and that they are never unknown after reset. They also assume that control bits are sampled only where a held level or a pair comparison does not depend on the clock phase. The stimulus changes its inputs only just after falling edges. It walks every address in each of the three modes, then sends random addresses and all four mode codes, including the unused one. The clocked control levels are read in both clock phases half a cycle apart, so that a following clock and an inverted clock can be told apart.

// File: rtl/adec_pkg.sv
package adec_pkg;

    localparam int ADEC_ADDR_W = 10;

    typedef enum logic [1:0] {
        MODE_STATIC  = 2'b00,
        MODE_MIXED   = 2'b01,
        MODE_DYNAMIC = 2'b10,
        MODE_UNUSED  = 2'b11
    } adec_mode_e;

    typedef struct packed {
        logic       live;
        adec_mode_e mode;
    } adec_ctl_t;

    // NAND stages sit at even positions of the chain
    function automatic bit stage_is_nand(int s);
        return (s % 2) == 0;
    endfunction

endpackage

// File: rtl/adec_front_stage.sv
module adec_front_stage (
    input  logic [1:0] a_i,
    output logic [3:0] y_o
);
    logic [1:0] a_n;

    assign a_n = ~a_i;

    // four NOR gates, line j high when a_i == j
    assign y_o[0] = ~(a_i[0] | a_i[1]);
    assign y_o[1] = ~(a_n[0] | a_i[1]);
    assign y_o[2] = ~(a_i[0] | a_n[1]);
    assign y_o[3] = ~(a_n[0] | a_n[1]);
endmodule

// File: rtl/adec_tree_stage.sv
module adec_tree_stage #(
    parameter int STAGE = 2,
    parameter int IN_W  = 4
) (
    input  logic [IN_W-1:0]   in_v,
    input  logic              bit_i,
    output logic [2*IN_W-1:0] out_v
);
    logic bit_n;

    assign bit_n = ~bit_i;

    if (adec_pkg::stage_is_nand(STAGE)) begin : g_nand
        // active-high in, active-low out; upper block takes the true bit
        assign out_v = ~({in_v, in_v} & {{IN_W{bit_i}}, {IN_W{bit_n}}});
    end else begin : g_nor
        // active-low in, active-high out; lower block takes the true bit
        assign out_v = ~({in_v, in_v} | {{IN_W{bit_n}}, {IN_W{bit_i}}});
    end
endmodule

// File: rtl/adec_half_ctrl.sv
module adec_half_ctrl #(
    parameter bit TYPE_A = 1'b0
) (
    input  logic       bit_i,
    input  logic [1:0] mode_i,
    output logic       dyn_true_o,
    output logic       dyn_comp_o
);
    logic mixed, full_dyn, pick_true;

    assign mixed    = (mode_i == adec_pkg::MODE_MIXED);
    assign full_dyn = (mode_i == adec_pkg::MODE_DYNAMIC);
    // the half holding the selected path is the one clocked in mixed mode
    assign pick_true = TYPE_A ? bit_i : ~bit_i;

    assign dyn_true_o = full_dyn | (mixed & pick_true);
    assign dyn_comp_o = full_dyn | (mixed & ~pick_true);
endmodule

// File: rtl/adaptive_decoder.sv
module adaptive_decoder
    import adec_pkg::*;
#(
    parameter int ADDR_W = ADEC_ADDR_W,
    localparam int STAGES = ADDR_W - 1,
    localparam int WORDS  = 1 << ADDR_W,
    localparam int CTRL_W = 2 * STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        mode_i,
    output logic [WORDS-1:0]  word_o,
    output logic [CTRL_W-1:0] ctrl_o
);
    logic [ADDR_W-1:0] addr_q;
    adec_ctl_t         ctl_q;
    logic [CTRL_W-1:0] dyn_d, dyn_q;
    logic [WORDS-1:0]  word_q;

    // input capture
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            ctl_q  <= '{live: 1'b0, mode: MODE_STATIC};
        end else begin
            addr_q <= addr_i;
            ctl_q  <= '{live: 1'b1, mode: adec_mode_e'(mode_i)};
        end
    end

    for (genvar s = 1; s <= STAGES; s++) begin : g_st
        localparam bit NAND_ST = stage_is_nand(s);
        logic [(2 << s)-1:0] v;

        if (s == 1) begin : g_front
            adec_front_stage u_front (
                .a_i (addr_q[1:0]),
                .y_o (v)
            );
        end else begin : g_tree
            adec_tree_stage #(.STAGE(s), .IN_W(1 << s)) u_tree (
                .in_v  (g_st[s-1].v),
                .bit_i (addr_q[s]),
                .out_v (v)
            );
        end

        adec_half_ctrl #(.TYPE_A(NAND_ST)) u_ctrl (
            .bit_i      (addr_q[s]),
            .mode_i     (ctl_q.mode),
            .dyn_true_o (dyn_d[2*(s-1)]),
            .dyn_comp_o (dyn_d[2*(s-1)+1])
        );

        // clocked half: clock for NAND, inverted clock for NOR; else held
        assign ctrl_o[2*(s-1)]   = dyn_q[2*(s-1)]   ? (NAND_ST ? clk : ~clk) : NAND_ST;
        assign ctrl_o[2*(s-1)+1] = dyn_q[2*(s-1)+1] ? (NAND_ST ? clk : ~clk) : NAND_ST;
    end

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            dyn_q  <= '0;
        end else begin
            word_q <= ctl_q.live ? g_st[STAGES].v : '0;
            dyn_q  <= ctl_q.live ? dyn_d : '0;
        end
    end

    assign word_o = word_q;
endmodule

// File: rtl/adaptive_decoder_chk.sv
module adaptive_decoder_chk #(
    parameter int ADDR_W = 10,
    localparam int STAGES = ADDR_W - 1,
    localparam int WORDS  = 1 << ADDR_W,
    localparam int CTRL_W = 2 * STAGES
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr_i,
    input logic [1:0]        mode_i,
    input logic [WORDS-1:0]  word_o,
    input logic [CTRL_W-1:0] ctrl_o
);
    logic [1:0]        warm;
    logic [CTRL_W-1:0] held_lvl;
    logic [STAGES-1:0] pair_eq;

    always_ff @(posedge clk) begin
        if (rst)               warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    always_comb begin
        for (int i = 0; i < STAGES; i++) begin
            held_lvl[2*i]   = ((i + 1) % 2) == 0;
            held_lvl[2*i+1] = ((i + 1) % 2) == 0;
            pair_eq[i]      = ctrl_o[2*i] == ctrl_o[2*i+1];
        end
    end

    // R3
    word_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(word_o));

    // R2
    word_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2) |-> (word_o == (WORDS'(1) << $past(addr_i, 2))));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (word_o == '0 && ctrl_o == held_lvl));

    // R4
    static_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2 && ($past(mode_i, 2) == 2'b00 || $past(mode_i, 2) == 2'b11))
        |-> (ctrl_o == held_lvl));

    // R8
    dynamic_pairs_chk: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2 && $past(mode_i, 2) == 2'b10) |-> (&pair_eq));
endmodule

bind adaptive_decoder adaptive_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .addr_i (addr_i),
    .mode_i (mode_i),
    .word_o (word_o),
    .ctrl_o (ctrl_o)
);

// File: tb/adaptive_decoder_test.sv
module adaptive_decoder_test;
    localparam int AW = 10;
    localparam int NS = AW - 1;
    localparam int NW = 1 << AW;
    localparam int CW = 2 * NS;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [1:0]    mode = 2'b00;
    logic [NW-1:0] word;
    logic [CW-1:0] ctrl;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    adaptive_decoder uut (
        .clk    (clk),
        .rst    (rst),
        .addr_i (addr),
        .mode_i (mode),
        .word_o (word),
        .ctrl_o (ctrl)
    );

    always #2.5 clk = ~clk;

    function automatic logic [CW-1:0] exp_ctrl(int a, logic [1:0] m, logic c);
        logic [CW-1:0] r;
        for (int s = 1; s <= NS; s++) begin
            bit nand_st = (s % 2) == 0;
            bit b = ((a >> s) & 1) != 0;
            bit pick_true = nand_st ? b : !b;
            bit dt = (m == 2'b10) || (m == 2'b01 && pick_true);
            bit dc = (m == 2'b10) || (m == 2'b01 && !pick_true);
            logic run = nand_st ? c : ~c;
            r[2*(s-1)]   = dt ? run : logic'(nand_st);
            r[2*(s-1)+1] = dc ? run : logic'(nand_st);
        end
        return r;
    endfunction

    function automatic logic [NW-1:0] exp_word(int a);
        return NW'(1) << a;
    endfunction

    task automatic chk_word(string req, logic [NW-1:0] exp);
        checks++;
        if (word !== exp) begin
            errors++;
            $display("FAIL %s word: actual ones=%0d match=%0b expected line %0d",
                     req, $countones(word), word == exp, $clog2(exp));
        end
    endtask

    task automatic chk_ctrl(string req, logic [CW-1:0] exp);
        checks++;
        if (ctrl !== exp) begin
            errors++;
            $display("FAIL %s ctrl: actual %b expected %b", req, ctrl, exp);
        end
    endtask

    // drive at a falling edge, read after two rising edges in both clock phases
    task automatic apply(int a, logic [1:0] m, string req);
        @(negedge clk);
        addr = AW'(a);
        mode = m;
        @(posedge clk);
        @(posedge clk);
        #1;
        chk_word(req, exp_word(a));
        chk_ctrl(req, exp_ctrl(a, m, 1'b1));
        @(negedge clk);
        #1;
        chk_ctrl(req, exp_ctrl(a, m, 1'b0));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: reset state in both clock phases
        repeat (3) @(posedge clk);
        #1;
        chk_word("R1", '0);
        chk_ctrl("R1", exp_ctrl(0, 2'b00, 1'b1));
        @(negedge clk);
        #1;
        chk_ctrl("R1", exp_ctrl(0, 2'b00, 1'b0));
        addr = AW'(9);
        mode = 2'b10;
        rst  = 1'b0;
        // R1: first output cycle after reset is still cleared
        @(posedge clk);
        #1;
        chk_word("R1", '0);
        chk_ctrl("R1", exp_ctrl(0, 2'b00, 1'b1));

        // R3 R4 R5 R6 R7 R8 R9 R10: every address in each defined mode
        for (int m = 0; m < 3; m++)
            for (int a = 0; a < NW; a++)
                apply(a, 2'(m), m == 0 ? "R4" : (m == 1 ? "R5_R6_R9" : "R8_R7"));

        // R2: one edge after capture the old line still shows
        apply(5, 2'b01, "R3");
        @(negedge clk);
        addr = AW'(700);
        @(posedge clk);
        #1;
        chk_word("R2", exp_word(5));
        @(posedge clk);
        #1;
        chk_word("R2", exp_word(700));

        // R4: the unused mode code holds every half
        apply(NW - 1, 2'b11, "R4");
        apply(0, 2'b11, "R4");
        apply(682, 2'b11, "R4");

        // R10 R5 R6: random addresses under random modes
        for (int i = 0; i < 400; i++)
            apply(int'($urandom % NW), 2'($urandom % 4), "R10");

        // R1: reset in mid-run clears the outputs
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk_word("R1", '0);
        chk_ctrl("R1", exp_ctrl(0, 2'b00, 1'b1));
        @(negedge clk);
        rst = 1'b0;
        apply(1023, 2'b01, "R3");
        finish_run();
    end
endmodule